// File: doc/BRIEF.md
# Dual-Window Watchdog Supervisor

This block is a clocked window watchdog for a processor that runs in an active mode and a sleep mode. After power-on it holds the processor in reset for a fixed time. It then waits for the processor to request monitoring by driving the mode input low. While it monitors, it enforces a closed/open trigger window. The window is short while the mode input is low and long while it is high. A trigger that comes too early, a trigger low phase that lasts too long, or a missing trigger produces a reset pulse. After every reset pulse the block goes back to waiting for the mode request.

All inputs arrive already debounced: the trigger level, the mode level, a one-cycle trigger-rising flag, a trigger-error flag and a one-cycle wake-up edge flag. A wake-up edge during the long window ends sleep monitoring with a reset pulse. A separate enable output turns on safety-critical peripherals. It asserts only after a run of consecutive good triggers in the short window.

All durations are counted in clock cycles and are parameters. One shared timer restarts on every state change. Its clear takes effect one clock after the change, so each state lasts exactly its parameter in cycles.

Top module: `wdw_supervisor`

## Requirements
- R1: After the synchronous power-on input `rst` is released, `rst_n_out` stays low for exactly P_PWRUP cycles, counting the first cycle after release, and `enable_out` is low.
- R2: In the mode-wait state, a low `mode_lvl` moves the block into the short closed window on the next cycle. If `mode_lvl` stays high for P_MODESW cycles, a reset pulse starts.
- R3: A reset pulse holds `rst_n_out` low for exactly P_RSTOUT cycles. The block then returns to the mode-wait state with `rst_n_out` high.
- R4: In the short closed window, which lasts P_SDIS cycles, a low `trig_lvl` or a high `trig_err` starts a reset pulse on the next cycle. This includes the window's last cycle.
- R5: In the short open window, `trig_rise` starts a new short closed window. A `trig_err` starts a reset pulse and takes priority over `trig_rise`. If no trigger arrives for P_SEN cycles, a reset pulse starts.
- R6: `enable_out` goes high in the cycle after the P_GOODS-th consecutive good trigger (P_GOODS = 3 by default), and only while the short window is in use. A reset pulse, a trigger error, a power-on or entry into the long window clears the run.
- R7: A high `mode_lvl` in either short-window state moves the block to the long closed window on the next cycle. `enable_out` stays low throughout the long window, even when triggers are good.
- R8: The long window follows the same closed/open rules as the short one, with P_LDIS closed cycles and P_LEN open cycles.
- R9: `wake_edge` in either long-window state starts a reset pulse on the next cycle. In the short window it has no effect.
- R10: A low `mode_lvl` in either long-window state moves the block to the short closed window on the next cycle.
- R11: A high `rst` at any time forces the power-up state. The next release replays R1, and the good-trigger run starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all durations counted on it |
| rst | input | 1 | Synchronous active-high power-on reset |
| trig_lvl | input | 1 | Debounced trigger level, idle high |
| mode_lvl | input | 1 | Debounced mode level: low = short window, high = long window |
| trig_rise | input | 1 | One-cycle flag for a trigger rising edge |
| trig_err | input | 1 | Flag: trigger low phase too long |
| wake_edge | input | 1 | One-cycle flag for a debounced wake-up edge |
| rst_n_out | output | 1 | Active-low reset to the processor |
| enable_out | output | 1 | Enable for safety-critical peripherals |

## Verification
The bench uses scaled-down durations and computes every expected reset edge by adding window lengths from the moment of entry. Trigger lows are placed on the last closed cycle and on the first open cycle. A reset in the first case and none in the second shows where each window boundary lies. The bench counts runs of one, two and three good triggers, sends an error together with a rising edge, and moves between the windows in both directions. These cases separate the enable counting from the state sequencing. Wake-up edges are sent in both long states and in the short window, where they must have no effect.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP  = 3'd0,
        ST_MODESW = 3'd1,
        ST_SDIS   = 3'd2,
        ST_SEN    = 3'd3,
        ST_LDIS   = 3'd4,
        ST_LEN    = 3'd5,
        ST_RSTOUT = 3'd6
    } wd_state_t;

    function automatic logic in_short(input wd_state_t s);
        return (s == ST_SDIS) || (s == ST_SEN);
    endfunction

    function automatic logic in_long(input wd_state_t s);
        return (s == ST_LDIS) || (s == ST_LEN);
    endfunction

    function automatic logic holds_reset(input wd_state_t s);
        return (s == ST_PWRUP) || (s == ST_RSTOUT);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdw_timer.sv
module wdw_timer #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          changed,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic          moved_q;
    logic [CW-1:0] cnt_q;

    // The clear lands one clock after a state change; the stale count in
    // that first cycle is masked so it cannot end the new state early.
    always_ff @(posedge clk) begin
        if (rst) begin
            moved_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            moved_q <= changed;
            if (moved_q)
                cnt_q <= '0;
            else if (cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = !moved_q && (cnt_q == limit - CW'(2));

    assert_count_fresh_R11: assert property (@(posedge clk) disable iff (rst)
        $past(moved_q) |-> !expired || (limit == CW'(2)));
endmodule

// File: rtl/wdw_fsm.sv
module wdw_fsm
    import wdw_pkg::*;
#(
    parameter int CW       = 17,
    parameter int P_PWRUP  = 201,
    parameter int P_MODESW = 1112,
    parameter int P_SDIS   = 130,
    parameter int P_SEN    = 124,
    parameter int P_LDIS   = 71970,
    parameter int P_LEN    = 30002,
    parameter int P_RSTOUT = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig_lvl,
    input  logic          mode_lvl,
    input  logic          trig_rise,
    input  logic          trig_err,
    input  logic          wake_edge,
    input  logic          expired,
    output wd_state_t     state,
    output logic          changed,
    output logic [CW-1:0] limit,
    output logic          good_trig
);
    wd_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PWRUP:  if (expired) st_d = ST_MODESW;
            ST_MODESW: begin
                if (!mode_lvl)    st_d = ST_SDIS;
                else if (expired) st_d = ST_RSTOUT;
            end
            ST_SDIS: begin
                if (!trig_lvl || trig_err) st_d = ST_RSTOUT;
                else if (mode_lvl)         st_d = ST_LDIS;
                else if (expired)          st_d = ST_SEN;
            end
            ST_SEN: begin
                if (trig_err)       st_d = ST_RSTOUT;
                else if (trig_rise) st_d = ST_SDIS;
                else if (mode_lvl)  st_d = ST_LDIS;
                else if (expired)   st_d = ST_RSTOUT;
            end
            ST_LDIS: begin
                if (!trig_lvl || trig_err || wake_edge) st_d = ST_RSTOUT;
                else if (!mode_lvl)                     st_d = ST_SDIS;
                else if (expired)                       st_d = ST_LEN;
            end
            ST_LEN: begin
                if (trig_err || wake_edge) st_d = ST_RSTOUT;
                else if (trig_rise)        st_d = ST_LDIS;
                else if (!mode_lvl)        st_d = ST_SDIS;
                else if (expired)          st_d = ST_RSTOUT;
            end
            ST_RSTOUT: if (expired) st_d = ST_MODESW;
            default:   st_d = ST_PWRUP;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_PWRUP:  limit = CW'(P_PWRUP);
            ST_MODESW: limit = CW'(P_MODESW);
            ST_SDIS:   limit = CW'(P_SDIS);
            ST_SEN:    limit = CW'(P_SEN);
            ST_LDIS:   limit = CW'(P_LDIS);
            ST_LEN:    limit = CW'(P_LEN);
            default:   limit = CW'(P_RSTOUT);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_PWRUP;
        else     st_q <= st_d;
    end

    assign state     = st_q;
    assign changed   = (st_d != st_q);
    assign good_trig = (st_q == ST_SEN) && trig_rise && !trig_err;

    assert_modesw_go_short_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MODESW && !mode_lvl) |=> (st_q == ST_SDIS));
    assert_pulse_returns_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_RSTOUT && st_q != ST_RSTOUT) |-> (st_q == ST_MODESW));
    assert_closed_error_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SDIS && trig_err) |=> (st_q == ST_RSTOUT));
    assert_err_beats_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SEN && trig_err && trig_rise) |=> (st_q == ST_RSTOUT));
    assert_wake_long_R9: assert property (@(posedge clk) disable iff (rst)
        (in_long(st_q) && wake_edge) |=> (st_q == ST_RSTOUT));
    assert_long_to_short_R10: assert property (@(posedge clk) disable iff (rst)
        (in_long(st_q) && !mode_lvl && trig_lvl && !trig_err && !wake_edge && !trig_rise)
        |=> (st_q == ST_SDIS));
endmodule

// File: rtl/wdw_engate.sv
module wdw_engate
    import wdw_pkg::*;
#(
    parameter int P_GOODS = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  wd_state_t state,
    input  logic      good_trig,
    input  logic      trig_err,
    output logic      enable_out
);
    localparam int GW = $clog2(P_GOODS + 1);

    logic [GW-1:0] run_q;
    logic          wipe;

    assign wipe = trig_err || !in_short(state);

    always_ff @(posedge clk) begin
        if (rst || wipe)
            run_q <= '0;
        else if (good_trig && run_q != GW'(P_GOODS))
            run_q <= run_q + 1'b1;
    end

    assign enable_out = (run_q == GW'(P_GOODS)) && in_short(state);

    assert_enable_after_good_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(enable_out) |-> $past(good_trig));
    assert_enable_off_long_R7: assert property (@(posedge clk) disable iff (rst)
        in_long(state) |-> !enable_out);
endmodule

// File: rtl/wdw_supervisor.sv
module wdw_supervisor
    import wdw_pkg::*;
#(
    parameter int P_PWRUP  = 201,
    parameter int P_MODESW = 1112,
    parameter int P_SDIS   = 130,
    parameter int P_SEN    = 124,
    parameter int P_LDIS   = 71970,
    parameter int P_LEN    = 30002,
    parameter int P_RSTOUT = 40,
    parameter int P_GOODS  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_lvl,
    input  logic mode_lvl,
    input  logic trig_rise,
    input  logic trig_err,
    input  logic wake_edge,
    output logic rst_n_out,
    output logic enable_out
);
    localparam int MAXD = max2(max2(max2(P_PWRUP, P_MODESW), max2(P_SDIS, P_SEN)),
                               max2(max2(P_LDIS, P_LEN), P_RSTOUT));
    localparam int CW   = $clog2(MAXD + 1);

    wd_state_t     state;
    logic          changed;
    logic          expired;
    logic          good_trig;
    logic [CW-1:0] limit;

    wdw_fsm #(
        .CW(CW), .P_PWRUP(P_PWRUP), .P_MODESW(P_MODESW), .P_SDIS(P_SDIS),
        .P_SEN(P_SEN), .P_LDIS(P_LDIS), .P_LEN(P_LEN), .P_RSTOUT(P_RSTOUT)
    ) u_fsm (
        .clk(clk), .rst(rst), .trig_lvl(trig_lvl), .mode_lvl(mode_lvl),
        .trig_rise(trig_rise), .trig_err(trig_err), .wake_edge(wake_edge),
        .expired(expired), .state(state), .changed(changed), .limit(limit),
        .good_trig(good_trig)
    );

    wdw_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .changed(changed), .limit(limit), .expired(expired)
    );

    wdw_engate #(.P_GOODS(P_GOODS)) u_gate (
        .clk(clk), .rst(rst), .state(state), .good_trig(good_trig),
        .trig_err(trig_err), .enable_out(enable_out)
    );

    assign rst_n_out = !holds_reset(state);

    assert_pwrup_low_R1: assert property (@(posedge clk)
        $past(rst) |-> (!rst_n_out && !enable_out));
endmodule

// File: tb/wdw_supervisor_tb.sv
module wdw_supervisor_tb;
    localparam int PW = 5, MS = 12, SD = 6, SE = 5, LD = 20, LE = 10, RO = 4;

    logic clk = 1'b0;
    logic rst = 1'b1, trig = 1'b1, mode = 1'b1, rise = 1'b0, err = 1'b0, wake = 1'b0;
    logic rst_n_out, enable_out;
    int   total = 0, bad = 0;

    always #5 clk = ~clk;

    wdw_supervisor #(
        .P_PWRUP(PW), .P_MODESW(MS), .P_SDIS(SD), .P_SEN(SE),
        .P_LDIS(LD), .P_LEN(LE), .P_RSTOUT(RO), .P_GOODS(3)
    ) u_dut (
        .clk(clk), .rst(rst), .trig_lvl(trig), .mode_lvl(mode), .trig_rise(rise),
        .trig_err(err), .wake_edge(wake), .rst_n_out(rst_n_out), .enable_out(enable_out)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // From the first cycle of a short closed window, one good trigger;
    // ends on the first cycle of the next closed window.
    task automatic good_trig();
        tick(SD);
        trig = 1'b0;
        tick(1);
        trig = 1'b1; rise = 1'b1;
        tick(1);
        rise = 1'b0;
    endtask

    // From the first cycle of a reset pulse to the first short closed cycle.
    task automatic recover();
        tick(RO);
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        chk("R1 reset low at release", rst_n_out, 1'b0);
        chk("R1 enable low at release", enable_out, 1'b0);
        tick(PW - 1);
        chk("R1 last power-up cycle", rst_n_out, 1'b0);
        tick(1);
        chk("R1 released after P_PWRUP", rst_n_out, 1'b1);

        tick(MS - 1);
        chk("R2 mode-wait last cycle", rst_n_out, 1'b1);
        tick(1);
        chk("R2 mode timeout pulse", rst_n_out, 1'b0);
        tick(RO - 1);
        chk("R3 pulse last cycle", rst_n_out, 1'b0);
        tick(1);
        chk("R3 pulse ends", rst_n_out, 1'b1);
        mode = 1'b0;
        tick(1);
        chk("R2 mode low enters short", rst_n_out, 1'b1);

        good_trig();
        chk("R6 one good trigger", enable_out, 1'b0);
        good_trig();
        chk("R6 two good triggers", enable_out, 1'b0);
        good_trig();
        chk("R6 three good triggers", enable_out, 1'b1);
        chk("R5 good triggers no reset", rst_n_out, 1'b1);

        tick(SD + SE - 1);
        chk("R5 open window last cycle", rst_n_out, 1'b1);
        chk("R6 enable held in window", enable_out, 1'b1);
        tick(1);
        chk("R5 missing trigger reset", rst_n_out, 1'b0);
        chk("R6 reset clears enable", enable_out, 1'b0);
        recover();
        chk("R3 back in short window", rst_n_out, 1'b1);
        chk("R6 run restarts after reset", enable_out, 1'b0);

        tick(SD - 1);
        trig = 1'b0;
        tick(1);
        chk("R4 trigger low on last closed cycle", rst_n_out, 1'b0);
        trig = 1'b1;
        recover();

        for (int k = 0; k < 3; k++) good_trig();
        tick(SD);
        err = 1'b1; rise = 1'b1;
        tick(1);
        err = 1'b0; rise = 1'b0;
        chk("R5 error beats rise", rst_n_out, 1'b0);
        chk("R6 error clears enable", enable_out, 1'b0);
        recover();

        tick(2);
        err = 1'b1;
        tick(1);
        err = 1'b0;
        chk("R4 error in closed window", rst_n_out, 1'b0);
        recover();

        for (int k = 0; k < 3; k++) good_trig();
        chk("R6 enable before long", enable_out, 1'b1);
        mode = 1'b1;
        tick(1);
        chk("R7 long window enable off", enable_out, 1'b0);
        chk("R7 long window no reset", rst_n_out, 1'b1);
        tick(LD);
        trig = 1'b0;
        tick(1);
        trig = 1'b1; rise = 1'b1;
        tick(1);
        rise = 1'b0;
        chk("R8 trigger on first long open cycle", rst_n_out, 1'b1);
        chk("R7 long trigger keeps enable off", enable_out, 1'b0);
        tick(LD + LE - 1);
        chk("R8 long open last cycle", rst_n_out, 1'b1);
        tick(1);
        chk("R8 long missing trigger reset", rst_n_out, 1'b0);
        mode = 1'b0;
        recover();

        mode = 1'b1;
        tick(1);
        tick(LD - 1);
        trig = 1'b0;
        tick(1);
        chk("R8 trigger low last long closed cycle", rst_n_out, 1'b0);
        trig = 1'b1; mode = 1'b0;
        recover();

        mode = 1'b1;
        tick(4);
        wake = 1'b1;
        tick(1);
        wake = 1'b0;
        chk("R9 wake in long closed", rst_n_out, 1'b0);
        mode = 1'b0;
        recover();

        mode = 1'b1;
        tick(1);
        tick(LD + 2);
        wake = 1'b1;
        tick(1);
        wake = 1'b0;
        chk("R9 wake in long open", rst_n_out, 1'b0);
        mode = 1'b0;
        recover();

        tick(2);
        wake = 1'b1;
        tick(1);
        wake = 1'b0;
        chk("R9 wake ignored in short", rst_n_out, 1'b1);
        tick(SD + SE - 4);
        chk("R9 short timing unchanged", rst_n_out, 1'b1);
        tick(1);
        chk("R9 short timeout after wake", rst_n_out, 1'b0);
        recover();

        mode = 1'b1;
        tick(4);
        mode = 1'b0;
        tick(1);
        chk("R10 back to short no reset", rst_n_out, 1'b1);
        tick(SD + SE - 1);
        chk("R10 short open last cycle", rst_n_out, 1'b1);
        tick(1);
        chk("R10 short timing after long", rst_n_out, 1'b0);
        recover();

        tick(SD + 1);
        mode = 1'b1;
        tick(1);
        tick(SE);
        chk("R7 open short to long no reset", rst_n_out, 1'b1);
        mode = 1'b0;
        tick(1);

        for (int k = 0; k < 3; k++) good_trig();
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R11 power-on forces reset", rst_n_out, 1'b0);
        chk("R11 power-on clears enable", enable_out, 1'b0);
        tick(PW - 1);
        chk("R11 power-up replay last cycle", rst_n_out, 1'b0);
        tick(1);
        chk("R11 power-up replay released", rst_n_out, 1'b1);
        tick(1);
        good_trig();
        good_trig();
        chk("R11 run restarted from zero", enable_out, 1'b0);
        good_trig();
        chk("R11 enable after new run", enable_out, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule